// File: doc/BRIEF.md
# Machine-Mode Trap Entry Unit

This block handles trap entry and trap return for one hart that runs only in machine mode. It owns the trap-related control state: the global interrupt enable and its saved copy, the three per-source interrupt enables, the trap vector base and mode, the saved program counter, the trap cause and the trap value. The pipeline raises synchronous exceptions with a cause code, a faulting address and the faulting instruction word. Level request lines arrive from the software, timer and external interrupt sources. The pipeline also presents the PC of the instruction at the trap point and a return request.

On each clock edge the unit picks at most one event. A synchronous exception comes first, then an enabled interrupt, then a return. It updates the trap state and, one cycle later, presents a redirect strobe with the next program counter. In vectored mode, interrupts land at the vector base plus four times their code. The external source always uses code 11, so it enters at offset 0x2C. Exceptions always land at the base. A small register port, using the standard machine CSR numbers, lets software read and write the state.

Top module: `mtrap_unit`

## Requirements
- R1: While reset is held and after it is released, with no event, `redir_valid_o` is 0 and `redir_pc_o` equals `RESET_VEC`. mstatus (0x300) reads 0x1800: privilege field bits 12:11 = 3, MIE bit 3 = 0, MPRV bit 17 = 0. mtvec reads 0.
- R2: An interrupt is taken only when its line is high, mstatus bit 3 is set, and its enable bit in mie (0x304) is set. The enable bits are bit 3 for software, bit 7 for timer and bit 11 for external. Otherwise no redirect occurs.
- R3: When several enabled interrupts are pending, external (code 11) wins over software (code 3), which wins over timer (code 7).
- R4: A synchronous exception on the same edge as a takeable interrupt or a return request wins. It redirects to the mtvec base and records its own cause.
- R5: In direct mode (mtvec bit 0 = 0), every trap redirects to mtvec with bits 1:0 cleared.
- R6: In vectored mode (mtvec bit 0 = 1), an interrupt redirects to base + 4 × code, so external goes to base + 0x2C. Exceptions still go to the base.
- R7: mtval receives a different value depending on the cause.
  - Causes 0, 1, 3, 4, 5, 6, 7, 12, 13 and 15 store the faulting address.
  - Cause 2 (illegal instruction) stores the instruction word.
  - Every other exception and every interrupt stores 0.
- R8: Trap entry has these effects:
  - mepc (0x341) receives `pc_i` with bits 1:0 cleared.
  - mstatus bit 7 (MPIE) receives the old bit 3.
  - Bit 3 is cleared.
  - mcause (0x342) holds the code in its low bits, with bit 31 set for an interrupt and clear for an exception.
- R9: A return request with no exception or takeable interrupt copies bit 7 into bit 3, sets bit 7, and redirects to mepc.
- R10: `redir_valid_o` is high for exactly the one cycle after the edge that accepts an event, and `redir_pc_o` is valid in that cycle.
- R11: The register port behaves as follows:
  - `csr_rdata_o` returns the addressed register one cycle after the address is presented.
  - mtvec bit 1 always reads 0.
  - mip (0x344) bits 3/7/11 show the raw request lines.
  - A write on an edge that also takes a trap or a return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_sw_i | input | 1 | Software interrupt request line (level) |
| irq_tmr_i | input | 1 | Timer interrupt request line (level) |
| irq_ext_i | input | 1 | External interrupt request line (level) |
| exc_valid_i | input | 1 | Synchronous exception request for this cycle |
| exc_cause_i | input | 5 | Exception code |
| exc_tval_i | input | XLEN | Faulting effective address |
| exc_insn_i | input | XLEN | Faulting instruction word |
| pc_i | input | XLEN | PC of the instruction at the trap point |
| mret_i | input | 1 | Trap return request |
| csr_we_i | input | 1 | Register write enable |
| csr_addr_i | input | 12 | Register number |
| csr_wdata_i | input | XLEN | Register write data |
| csr_rdata_o | output | XLEN | Registered read data |
| redir_valid_o | output | 1 | One-cycle redirect strobe |
| redir_pc_o | output | XLEN | Next program counter |

## Verification
The assertions assume that the request inputs are clean and meaningful on every edge after reset. They assume that `pc_i` is the PC the hart would save, and that an exception or return request lasts one cycle per event. The stimulus changes inputs only at falling edges and keeps every pulse one cycle long. It lowers or raises interrupt lines only while the global enable is clear, or where a specific entry order is being checked. This way each trap the checker sees matches a single intended event.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

  localparam logic [11:0] A_MSTATUS = 12'h300;
  localparam logic [11:0] A_MIE     = 12'h304;
  localparam logic [11:0] A_MTVEC   = 12'h305;
  localparam logic [11:0] A_MEPC    = 12'h341;
  localparam logic [11:0] A_MCAUSE  = 12'h342;
  localparam logic [11:0] A_MTVAL   = 12'h343;
  localparam logic [11:0] A_MIP     = 12'h344;

  localparam int B_GIE = 3;
  localparam int B_PIE = 7;

  // interrupt sources in priority order: external, software, timer
  localparam int NSRC = 3;
  localparam logic [4:0] SRC_CODE [NSRC] = '{5'd11, 5'd3, 5'd7};
  localparam int         SRC_BIT  [NSRC] = '{11, 3, 7};

  localparam logic [4:0] C_ILLEGAL = 5'd2;

  typedef enum logic [1:0] {ACT_NONE, ACT_EXC, ACT_IRQ, ACT_RET} act_e;

  // causes whose trap value is the faulting address
  function automatic logic cause_has_addr(input logic [4:0] c);
    case (c)
      5'd0, 5'd1, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7,
      5'd12, 5'd13, 5'd15: cause_has_addr = 1'b1;
      default:             cause_has_addr = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mtrap_irq_arb.sv
module mtrap_irq_arb
  import mtrap_pkg::*;
(
  input  logic [NSRC-1:0] line_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            gie_i,
  output logic            fire_o,
  output logic [NSRC-1:0] grant_o,
  output logic [4:0]      code_o
);

  logic [NSRC-1:0] req;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_req
      assign req[g] = line_i[g] & en_i[g] & gie_i;
    end
  endgenerate

  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    code_o  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && !found) begin
        grant_o[i] = 1'b1;
        code_o     = SRC_CODE[i];
        found      = 1'b1;
      end
    end
    fire_o = found;
  end

endmodule

// File: rtl/mtrap_target.sv
module mtrap_target #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] mtvec_i,
  input  logic            is_irq_i,
  input  logic [4:0]      code_i,
  output logic [XLEN-1:0] pc_o
);

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  always_comb begin
    base   = mtvec_i & ~XLEN'(3);
    offset = XLEN'(code_i) << 2;
    if (mtvec_i[0] && is_irq_i) pc_o = base + offset;
    else                        pc_o = base;
  end

endmodule

// File: rtl/mtrap_csr_file.sv
module mtrap_csr_file
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  act_e            act_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] tval_i,
  input  logic [4:0]      code_i,
  input  logic            we_i,
  input  logic [11:0]     addr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [NSRC-1:0] line_i,
  output logic            gie_o,
  output logic            pie_o,
  output logic [NSRC-1:0] en_o,
  output logic [XLEN-1:0] mtvec_o,
  output logic [XLEN-1:0] mepc_o,
  output logic [XLEN-1:0] rdata_o
);

  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

  logic            gie_q, pie_q;
  logic [NSRC-1:0] en_q;
  logic [XLEN-1:0] mtvec_q, mepc_q, mcause_q, mtval_q;
  logic [XLEN-1:0] rd_val;
  logic [XLEN-1:0] en_word, line_word;
  logic [NSRC-1:0] en_wr;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_bits
      assign en_wr[g] = wdata_i[SRC_BIT[g]];
    end
  endgenerate

  always_comb begin
    en_word   = '0;
    line_word = '0;
    for (int i = 0; i < NSRC; i++) begin
      en_word[SRC_BIT[i]]   = en_q[i];
      line_word[SRC_BIT[i]] = line_i[i];
    end
  end

  always_comb begin
    rd_val = '0;
    case (addr_i)
      A_MSTATUS: begin
        rd_val[12:11] = 2'b11;
        rd_val[B_PIE] = pie_q;
        rd_val[B_GIE] = gie_q;
      end
      A_MIE:    rd_val = en_word;
      A_MIP:    rd_val = line_word;
      A_MTVEC:  rd_val = mtvec_q;
      A_MEPC:   rd_val = mepc_q;
      A_MCAUSE: rd_val = mcause_q;
      A_MTVAL:  rd_val = mtval_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q    <= 1'b0;
      pie_q    <= 1'b0;
      en_q     <= '0;
      mtvec_q  <= '0;
      mepc_q   <= '0;
      mcause_q <= '0;
      mtval_q  <= '0;
      rdata_o  <= '0;
    end else begin
      rdata_o <= rd_val;
      case (act_i)
        ACT_EXC, ACT_IRQ: begin
          pie_q    <= gie_q;
          gie_q    <= 1'b0;
          mepc_q   <= pc_i & ALIGN_MASK;
          mcause_q <= {act_i == ACT_IRQ, {(XLEN-6){1'b0}}, code_i};
          mtval_q  <= tval_i;
        end
        ACT_RET: begin
          gie_q <= pie_q;
          pie_q <= 1'b1;
        end
        default: begin
          if (we_i) begin
            case (addr_i)
              A_MSTATUS: begin
                gie_q <= wdata_i[B_GIE];
                pie_q <= wdata_i[B_PIE];
              end
              A_MIE:    en_q     <= en_wr;
              A_MTVEC:  mtvec_q  <= {wdata_i[XLEN-1:2], 1'b0, wdata_i[0]};
              A_MEPC:   mepc_q   <= wdata_i & ALIGN_MASK;
              A_MCAUSE: mcause_q <= wdata_i;
              A_MTVAL:  mtval_q  <= wdata_i;
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  assign gie_o   = gie_q;
  assign pie_o   = pie_q;
  assign en_o    = en_q;
  assign mtvec_o = mtvec_q;
  assign mepc_o  = mepc_q;

endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
  import mtrap_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            irq_sw_i,
  input  logic            irq_tmr_i,
  input  logic            irq_ext_i,
  input  logic            exc_valid_i,
  input  logic [4:0]      exc_cause_i,
  input  logic [XLEN-1:0] exc_tval_i,
  input  logic [XLEN-1:0] exc_insn_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            mret_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            redir_valid_o,
  output logic [XLEN-1:0] redir_pc_o
);

  logic [NSRC-1:0] lines;
  logic [NSRC-1:0] en;
  logic [NSRC-1:0] irq_grant;
  logic            irq_fire;
  logic [4:0]      irq_code;
  logic            gie, pie;
  logic [XLEN-1:0] mtvec_q, mepc_q;
  act_e            act;
  logic [4:0]      code;
  logic [XLEN-1:0] tval_sel;
  logic [XLEN-1:0] trap_pc;

  assign lines = {irq_tmr_i, irq_sw_i, irq_ext_i};

  mtrap_irq_arb u_arb (
    .line_i  (lines),
    .en_i    (en),
    .gie_i   (gie),
    .fire_o  (irq_fire),
    .grant_o (irq_grant),
    .code_o  (irq_code)
  );

  always_comb begin
    if (exc_valid_i)   act = ACT_EXC;
    else if (irq_fire) act = ACT_IRQ;
    else if (mret_i)   act = ACT_RET;
    else               act = ACT_NONE;
  end

  assign code = (act == ACT_EXC) ? exc_cause_i : irq_code;

  always_comb begin
    tval_sel = '0;
    if (act == ACT_EXC) begin
      if (exc_cause_i == C_ILLEGAL)          tval_sel = exc_insn_i;
      else if (cause_has_addr(exc_cause_i))  tval_sel = exc_tval_i;
    end
  end

  mtrap_target #(.XLEN(XLEN)) u_tgt (
    .mtvec_i  (mtvec_q),
    .is_irq_i (act == ACT_IRQ),
    .code_i   (code),
    .pc_o     (trap_pc)
  );

  mtrap_csr_file #(.XLEN(XLEN)) u_csr (
    .clk     (clk),
    .rst     (rst),
    .act_i   (act),
    .pc_i    (pc_i),
    .tval_i  (tval_sel),
    .code_i  (code),
    .we_i    (csr_we_i),
    .addr_i  (csr_addr_i),
    .wdata_i (csr_wdata_i),
    .line_i  (lines),
    .gie_o   (gie),
    .pie_o   (pie),
    .en_o    (en),
    .mtvec_o (mtvec_q),
    .mepc_o  (mepc_q),
    .rdata_o (csr_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid_o <= 1'b0;
      redir_pc_o    <= RESET_VEC;
    end else begin
      case (act)
        ACT_EXC, ACT_IRQ: begin
          redir_valid_o <= 1'b1;
          redir_pc_o    <= trap_pc;
        end
        ACT_RET: begin
          redir_valid_o <= 1'b1;
          redir_pc_o    <= mepc_q;
        end
        default: redir_valid_o <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/mtrap_checker.sv
module mtrap_checker
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            exc_valid_i,
  input logic            mret_i,
  input logic [XLEN-1:0] pc_i,
  input logic            irq_fire,
  input logic [NSRC-1:0] irq_grant,
  input logic            gie,
  input logic            pie,
  input logic [XLEN-1:0] mtvec_q,
  input logic [XLEN-1:0] mepc_q,
  input logic            redir_valid_o,
  input logic [XLEN-1:0] redir_pc_o
);

  // R2: with the global enable clear and no other event, nothing redirects
  a_r2_gated_off: assert property (@(posedge clk) disable iff (rst)
    (!gie && !exc_valid_i && !mret_i) |=> !redir_valid_o);

  // R3: the arbiter grants at most one source
  a_r3_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_grant));

  // R6: exceptions land on the base in either mode
  a_r6_exc_to_base: assert property (@(posedge clk) disable iff (rst)
    exc_valid_i |=> (redir_valid_o && redir_pc_o == ($past(mtvec_q) & ~XLEN'(3))));

  // R8: trap entry saves state and clears the global enable
  a_r8_entry_state: assert property (@(posedge clk) disable iff (rst)
    exc_valid_i |=> (!gie && pie == $past(gie) && mepc_q == ($past(pc_i) & ~XLEN'(3))));

  // R9: return restores the enable and redirects to the saved PC
  a_r9_return: assert property (@(posedge clk) disable iff (rst)
    (mret_i && !exc_valid_i && !irq_fire) |=>
      (redir_valid_o && redir_pc_o == $past(mepc_q) && gie == $past(pie) && pie));

  // R10: a redirect strobe always follows an accepted event
  a_r10_strobe_cause: assert property (@(posedge clk) disable iff (rst)
    redir_valid_o |-> $past(exc_valid_i || irq_fire || mret_i));

endmodule

bind mtrap_unit mtrap_checker #(.XLEN(XLEN)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .exc_valid_i   (exc_valid_i),
  .mret_i        (mret_i),
  .pc_i          (pc_i),
  .irq_fire      (irq_fire),
  .irq_grant     (irq_grant),
  .gie           (gie),
  .pie           (pie),
  .mtvec_q       (mtvec_q),
  .mepc_q        (mepc_q),
  .redir_valid_o (redir_valid_o),
  .redir_pc_o    (redir_pc_o)
);

// File: tb/tb_mtrap_unit.sv
module tb_mtrap_unit;
  import mtrap_pkg::*;

  localparam int          XLEN = 32;
  localparam logic [31:0] RV   = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst;
  logic        irq_sw, irq_tmr, irq_ext;
  logic        exc_valid;
  logic [4:0]  exc_cause;
  logic [31:0] exc_tval, exc_insn, pc;
  logic        mret;
  logic        csr_we;
  logic [11:0] csr_addr;
  logic [31:0] csr_wdata, csr_rdata;
  logic        redir_valid;
  logic [31:0] redir_pc;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mtrap_unit #(.XLEN(XLEN), .RESET_VEC(RV)) dut (
    .clk(clk), .rst(rst),
    .irq_sw_i(irq_sw), .irq_tmr_i(irq_tmr), .irq_ext_i(irq_ext),
    .exc_valid_i(exc_valid), .exc_cause_i(exc_cause),
    .exc_tval_i(exc_tval), .exc_insn_i(exc_insn), .pc_i(pc),
    .mret_i(mret),
    .csr_we_i(csr_we), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata),
    .csr_rdata_o(csr_rdata),
    .redir_valid_o(redir_valid), .redir_pc_o(redir_pc)
  );

  // exception table: cause and mtval kind (0 zero, 1 address, 2 instruction)
  localparam int NV = 8;
  localparam logic [4:0] V_CAUSE [NV] = '{5'd0, 5'd2, 5'd3, 5'd5, 5'd7, 5'd11, 5'd13, 5'd15};
  localparam logic [1:0] V_KIND  [NV] = '{2'd1, 2'd2, 2'd1, 2'd1, 2'd1, 2'd0, 2'd1, 2'd1};

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // finish a one-cycle pulse: wait past the edge, then drop pulse inputs
  task automatic fin();
    @(negedge clk);
    exc_valid = 1'b0;
    mret      = 1'b0;
    csr_we    = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    fin();
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    @(negedge clk);
    d = csr_rdata;
  endtask

  task automatic do_mret();
    @(negedge clk);
    mret = 1'b1;
    fin();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1;
    irq_sw = 0; irq_tmr = 0; irq_ext = 0;
    exc_valid = 0; exc_cause = '0; exc_tval = '0; exc_insn = '0; pc = '0;
    mret = 0; csr_we = 0; csr_addr = '0; csr_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", {31'b0, redir_valid}, 32'h0);
    chk("R1", "pc in reset", redir_pc, RV);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "valid after reset", {31'b0, redir_valid}, 32'h0);
    chk("R1", "pc after reset", redir_pc, RV);
    rd(A_MSTATUS, d); chk("R1", "mstatus", d, 32'h0000_1800);
    rd(A_MTVEC, d);   chk("R1", "mtvec", d, 32'h0);

    // direct mode base
    wr(A_MTVEC, 32'h0000_2000);

    // table walk over exception causes
    for (int i = 0; i < NV; i++) begin
      logic [31:0] exp_tv;
      @(negedge clk);
      exc_valid = 1'b1; exc_cause = V_CAUSE[i];
      pc = 32'h0000_0400 + 32'(i << 4);
      exc_tval = 32'hA000_0000 + 32'(i);
      exc_insn = 32'h5500_0000 + 32'(i);
      fin();
      chk("R5", "exc redirect valid", {31'b0, redir_valid}, 32'h1);
      chk("R5", "exc redirect pc", redir_pc, 32'h0000_2000);
      @(negedge clk);
      chk("R10", "strobe one cycle", {31'b0, redir_valid}, 32'h0);
      exp_tv = (V_KIND[i] == 2'd1) ? exc_tval : (V_KIND[i] == 2'd2) ? exc_insn : 32'h0;
      rd(A_MCAUSE, d); chk("R8", "mcause exc", d, {27'b0, V_CAUSE[i]});
      rd(A_MTVAL, d);  chk("R7", "mtval", d, exp_tv);
      rd(A_MEPC, d);   chk("R8", "mepc", d, pc);
    end

    // mepc alignment
    @(negedge clk);
    exc_valid = 1'b1; exc_cause = 5'd4; pc = 32'h0000_0702;
    fin();
    rd(A_MEPC, d); chk("R8", "mepc aligned", d, 32'h0000_0700);

    // return with saved enable 0
    do_mret();
    chk("R9", "mret valid", {31'b0, redir_valid}, 32'h1);
    chk("R9", "mret pc", redir_pc, 32'h0000_0700);
    rd(A_MSTATUS, d); chk("R9", "mstatus after mret", d, 32'h0000_1880);

    // interrupt gating
    pc = 32'h0000_0800;
    wr(A_MSTATUS, 32'h0000_0008);
    wr(A_MIE, 32'h0);
    @(negedge clk); irq_tmr = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R2", "no irq without mie bit", {31'b0, redir_valid}, 32'h0);
    end
    wr(A_MIE, 32'h0000_0080);
    chk("R2", "not before enable lands", {31'b0, redir_valid}, 32'h0);
    @(negedge clk);
    chk("R2", "timer taken", {31'b0, redir_valid}, 32'h1);
    chk("R5", "timer direct pc", redir_pc, 32'h0000_2000);
    rd(A_MCAUSE, d);  chk("R8", "mcause timer", d, 32'h8000_0007);
    rd(A_MTVAL, d);   chk("R7", "mtval irq", d, 32'h0);
    rd(A_MEPC, d);    chk("R8", "mepc irq", d, 32'h0000_0800);
    rd(A_MSTATUS, d); chk("R8", "mstatus after entry", d, 32'h0000_1880);
    @(negedge clk);
    chk("R2", "blocked after entry", {31'b0, redir_valid}, 32'h0);

    // vectored mode priority walk
    wr(A_MTVEC, 32'h0000_2001);
    wr(A_MIE, 32'h0000_0888);
    @(negedge clk); irq_sw = 1'b1; irq_ext = 1'b1;
    do_mret();
    chk("R9", "mret pc vec", redir_pc, 32'h0000_0800);
    @(negedge clk);
    chk("R3", "ext first", {31'b0, redir_valid}, 32'h1);
    chk("R6", "ext at base+0x2C", redir_pc, 32'h0000_202C);
    rd(A_MCAUSE, d); chk("R3", "mcause ext", d, 32'h8000_000B);
    @(negedge clk); irq_ext = 1'b0;
    do_mret();
    @(negedge clk);
    chk("R3", "sw second", redir_pc, 32'h0000_200C);
    @(negedge clk); irq_sw = 1'b0;
    do_mret();
    @(negedge clk);
    chk("R3", "timer last", redir_pc, 32'h0000_201C);
    rd(A_MCAUSE, d); chk("R6", "mcause timer vec", d, 32'h8000_0007);
    @(negedge clk); irq_tmr = 1'b0;

    // exception beats interrupt
    wr(A_MSTATUS, 32'h0000_0008);
    @(negedge clk);
    irq_ext = 1'b1; exc_valid = 1'b1; exc_cause = 5'd5; exc_tval = 32'h0000_BEEF;
    fin();
    chk("R4", "exc over irq pc", redir_pc, 32'h0000_2000);
    rd(A_MCAUSE, d); chk("R4", "exc over irq cause", d, 32'h0000_0005);
    @(negedge clk); irq_ext = 1'b0;

    // exception beats return; same-edge register write dropped
    @(negedge clk);
    exc_valid = 1'b1; exc_cause = 5'd3; mret = 1'b1; pc = 32'h0000_0900;
    csr_we = 1'b1; csr_addr = A_MEPC; csr_wdata = 32'h0000_5550;
    fin();
    chk("R4", "exc over mret pc", redir_pc, 32'h0000_2000);
    rd(A_MEPC, d); chk("R11", "write dropped on trap", d, 32'h0000_0900);

    // register port details
    wr(A_MTVEC, 32'h0000_3003);
    rd(A_MTVEC, d); chk("R11", "mtvec bit1", d, 32'h0000_3001);
    @(negedge clk); irq_sw = 1'b1;
    rd(A_MIP, d); chk("R11", "mip sw line", d, 32'h0000_0008);
    @(negedge clk); irq_sw = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule